// File: doc/BRIEF.md
# Motion Mask Tip Locator

The block reads one binary motion mask per frame, one pixel per valid cycle in raster order, each pixel tagged with its column and row. While the frame streams in it keeps the running extent of the set pixels (leftmost and rightmost column, topmost and bottommost row). It also keeps the column of the first set pixel in scan order, which is where the object touches its upper edge. Per-frame state clears on the valid pixel at (0, 0). The valid pixel at the last column of the last row closes the frame.

After the frame closes, a short pipeline decides how the object lies. The gap from the upper touch column to the left edge of the box is compared with the gap to the right edge. A smaller left gap means the object runs from upper-left to lower-right; otherwise it runs from lower-left to upper-right. The two box corners on that diagonal are the object's endpoints. The endpoint that sits on the outer border of the image is taken as the entry point and dropped, and the other is reported as the tip. Only subtraction and comparison are used, with no multiply or divide.

Top module: `tip_locator`

## Requirements
- R1: While rst_ni is low and after it rises, tip_x_o and tip_y_o are 0 and tip_valid_o is 0 until the first frame result.
- R2: Only cycles with pix_valid_i high contribute to a frame; pix_on_i is ignored while pix_valid_i is low. The bounding box is the minimum and maximum column and row over valid pixels with pix_on_i high.
- R3: Let top_x be the column of the first set pixel in raster order. Let dl = top_x - min_x and dr = max_x - top_x. If dl < dr, the endpoints are P1 = (min_x, min_y) and P2 = (max_x, max_y). Otherwise (ties included) they are P1 = (min_x, max_y) and P2 = (max_x, min_y).
- R4: If P1 lies on the image border the tip is P2; otherwise the tip is P1.
- R5: A point is on the border when its column is 0 or IMG_W-1, or its row is 0 or IMG_H-1 (default 640x480, 11-bit coordinates).
- R6: If the last pixel of a frame (column IMG_W-1, row IMG_H-1) is sampled at clock edge E, tip_valid_o is high for exactly the one cycle that follows edge E+2. The new tip appears on tip_x_o and tip_y_o at that same edge.
- R7: A frame with no set pixel produces no tip_valid_o pulse, and the previous tip is kept.
- R8: A valid pixel at (0, 0) starts a new frame and discards the old extent. A new frame that begins in the cycle right after the previous frame's last pixel does not disturb the result of the previous frame.
- R9: tip_x_o and tip_y_o change only at the edge where tip_valid_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_on_i | input | 1 | Mask value of the pixel |
| pix_x_i | input | 11 | Pixel column |
| pix_y_i | input | 11 | Pixel row |
| tip_x_o | output | 11 | Tip column |
| tip_y_o | output | 11 | Tip row |
| tip_valid_o | output | 1 | One-cycle pulse with a new tip |

## Verification
The two functions that can meet in one cycle are the end-of-frame evaluation and the start-of-frame clear of the extent registers. This happens when the pixel at (0, 0) of the next frame arrives in the cycle right after the last pixel of the previous one. The bench sends frame pairs back to back with no idle cycle between them. It then checks that the pulse and tip of the first frame match the model computed from that frame's mask alone. The second frame's result is judged the same way.

// File: rtl/tip_loc_pkg.sv
package tip_loc_pkg;
  parameter int unsigned COORD_W = 11;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
  } pt_t;

  typedef enum logic {
    DIAG_TL_BR = 1'b0,
    DIAG_BL_TR = 1'b1
  } diag_e;
endpackage

// File: rtl/tip_bound_acc.sv
module tip_bound_acc
  import tip_loc_pkg::*;
#(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pix_valid_i,
  input  logic   pix_on_i,
  input  coord_t pix_x_i,
  input  coord_t pix_y_i,
  output logic   eof_o,
  output logic   hit_o,
  output coord_t min_x_o,
  output coord_t max_x_o,
  output coord_t min_y_o,
  output coord_t max_y_o,
  output coord_t top_x_o
);
  localparam coord_t LAST_X = coord_t'(IMG_W - 1);
  localparam coord_t LAST_Y = coord_t'(IMG_H - 1);

  logic   sof, eof;
  logic   hit_q, hit_d;
  coord_t min_x_q, max_x_q, min_y_q, max_y_q, top_x_q;
  coord_t min_x_d, max_x_d, min_y_d, max_y_d, top_x_d;
  logic   eof_q;

  assign sof = pix_valid_i && (pix_x_i == '0) && (pix_y_i == '0);
  assign eof = pix_valid_i && (pix_x_i == LAST_X) && (pix_y_i == LAST_Y);

  always_comb begin
    if (sof) begin
      hit_d   = 1'b0;
      min_x_d = '1;
      max_x_d = '0;
      min_y_d = '1;
      max_y_d = '0;
      top_x_d = '0;
    end else begin
      hit_d   = hit_q;
      min_x_d = min_x_q;
      max_x_d = max_x_q;
      min_y_d = min_y_q;
      max_y_d = max_y_q;
      top_x_d = top_x_q;
    end
    if (pix_valid_i && pix_on_i) begin
      // first set pixel in raster order marks the upper touch column
      if (!hit_d) top_x_d = pix_x_i;
      hit_d = 1'b1;
      if (pix_x_i < min_x_d) min_x_d = pix_x_i;
      if (pix_x_i > max_x_d) max_x_d = pix_x_i;
      if (pix_y_i < min_y_d) min_y_d = pix_y_i;
      if (pix_y_i > max_y_d) max_y_d = pix_y_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      min_x_q <= '1;
      max_x_q <= '0;
      min_y_q <= '1;
      max_y_q <= '0;
      top_x_q <= '0;
      eof_q   <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      min_x_q <= min_x_d;
      max_x_q <= max_x_d;
      min_y_q <= min_y_d;
      max_y_q <= max_y_d;
      top_x_q <= top_x_d;
      eof_q   <= eof;
    end
  end

  assign eof_o   = eof_q;
  assign hit_o   = hit_q;
  assign min_x_o = min_x_q;
  assign max_x_o = max_x_q;
  assign min_y_o = min_y_q;
  assign max_y_o = max_y_q;
  assign top_x_o = top_x_q;

  AST_BOX_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> (min_x_q <= max_x_q) && (min_y_q <= max_y_q)); // R2

  AST_TOP_IN_BOX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> (top_x_q >= min_x_q) && (top_x_q <= max_x_q)); // R3
endmodule

// File: rtl/tip_diag_pick.sv
module tip_diag_pick
  import tip_loc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   eof_i,
  input  logic   hit_i,
  input  coord_t min_x_i,
  input  coord_t max_x_i,
  input  coord_t min_y_i,
  input  coord_t max_y_i,
  input  coord_t top_x_i,
  output logic   vld_o,
  output pt_t    p1_o,
  output pt_t    p2_o
);
  coord_t gap_l, gap_r;
  diag_e  diag;
  pt_t    p1_d, p2_d;
  pt_t    p1_q, p2_q;
  logic   vld_q;

  assign gap_l = top_x_i - min_x_i;
  assign gap_r = max_x_i - top_x_i;
  assign diag  = (gap_l < gap_r) ? DIAG_TL_BR : DIAG_BL_TR;

  always_comb begin
    p1_d.x = min_x_i;
    p2_d.x = max_x_i;
    if (diag == DIAG_TL_BR) begin
      p1_d.y = min_y_i;
      p2_d.y = max_y_i;
    end else begin
      p1_d.y = max_y_i;
      p2_d.y = min_y_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      p1_q  <= '0;
      p2_q  <= '0;
    end else begin
      vld_q <= eof_i && hit_i;
      if (eof_i) begin
        p1_q <= p1_d;
        p2_q <= p2_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign p1_o  = p1_q;
  assign p2_o  = p2_q;
endmodule

// File: rtl/tip_select.sv
module tip_select
  import tip_loc_pkg::*;
#(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vld_i,
  input  pt_t    p1_i,
  input  pt_t    p2_i,
  output coord_t tip_x_o,
  output coord_t tip_y_o,
  output logic   tip_valid_o
);
  localparam coord_t LAST_X = coord_t'(IMG_W - 1);
  localparam coord_t LAST_Y = coord_t'(IMG_H - 1);

  logic p1_edge;
  pt_t  tip_d, tip_q;
  logic vld_q;

  assign p1_edge = (p1_i.x == '0) || (p1_i.x == LAST_X) ||
                   (p1_i.y == '0) || (p1_i.y == LAST_Y);
  assign tip_d   = p1_edge ? p2_i : p1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) tip_q <= tip_d;
    end
  end

  assign tip_x_o     = tip_q.x;
  assign tip_y_o     = tip_q.y;
  assign tip_valid_o = vld_q;

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R6

  AST_TIP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_q != $past(tip_q)) |-> vld_q); // R9

  AST_TIP_IN_IMG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (tip_q.x <= LAST_X) && (tip_q.y <= LAST_Y)); // R5
endmodule

// File: rtl/tip_locator.sv
module tip_locator
  import tip_loc_pkg::*;
#(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pix_valid_i,
  input  logic        pix_on_i,
  input  logic [10:0] pix_x_i,
  input  logic [10:0] pix_y_i,
  output logic [10:0] tip_x_o,
  output logic [10:0] tip_y_o,
  output logic        tip_valid_o
);
  logic   eof_q, hit_q, pick_vld;
  coord_t min_x, max_x, min_y, max_y, top_x;
  pt_t    p1, p2;

  tip_bound_acc #(.IMG_W(IMG_W), .IMG_H(IMG_H)) acc_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_on_i    (pix_on_i),
    .pix_x_i     (pix_x_i),
    .pix_y_i     (pix_y_i),
    .eof_o       (eof_q),
    .hit_o       (hit_q),
    .min_x_o     (min_x),
    .max_x_o     (max_x),
    .min_y_o     (min_y),
    .max_y_o     (max_y),
    .top_x_o     (top_x)
  );

  tip_diag_pick pick_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eof_i   (eof_q),
    .hit_i   (hit_q),
    .min_x_i (min_x),
    .max_x_i (max_x),
    .min_y_i (min_y),
    .max_y_i (max_y),
    .top_x_i (top_x),
    .vld_o   (pick_vld),
    .p1_o    (p1),
    .p2_o    (p2)
  );

  tip_select #(.IMG_W(IMG_W), .IMG_H(IMG_H)) sel_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (pick_vld),
    .p1_i        (p1),
    .p2_i        (p2),
    .tip_x_o     (tip_x_o),
    .tip_y_o     (tip_y_o),
    .tip_valid_o (tip_valid_o)
  );

  AST_EMPTY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_q && !hit_q) |=> ##1 !tip_valid_o); // R7
endmodule

// File: tb/tip_locator_tb.sv
module tip_locator_tb_top;
  localparam int W = 32;
  localparam int H = 24;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_on = 1'b0;
  logic [10:0] pix_x = '0;
  logic [10:0] pix_y = '0;
  logic [10:0] tip_x, tip_y;
  logic        tip_valid;

  tip_locator #(.IMG_W(W), .IMG_H(H)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_valid_i (pix_valid),
    .pix_on_i    (pix_on),
    .pix_x_i     (pix_x),
    .pix_y_i     (pix_y),
    .tip_x_o     (tip_x),
    .tip_y_o     (tip_y),
    .tip_valid_o (tip_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mask [H][W];

  // pending expectation for the frame in flight
  bit    pend = 0;
  int    due = 0;
  bit    exp_hit = 0;
  int    exp_x = 0, exp_y = 0;
  int    last_x = 0, last_y = 0;
  string exp_tag = "";

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual cyc=%0d expected < %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit on_edge(input int x, input int y);
    return (x == 0) || (x == W-1) || (y == 0) || (y == H-1);
  endfunction

  task automatic model(output bit hit, output int tx, output int ty);
    int mnx = W, mxx = -1, mny = H, mxy = -1, topx = 0;
    int p1x, p1y, p2x, p2y;
    hit = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (mask[y][x]) begin
          if (!hit) topx = x;
          hit = 1;
          if (x < mnx) mnx = x;
          if (x > mxx) mxx = x;
          if (y < mny) mny = y;
          if (y > mxy) mxy = y;
        end
    tx = 0; ty = 0;
    if (hit) begin
      p1x = mnx; p2x = mxx;
      if ((topx - mnx) < (mxx - topx)) begin p1y = mny; p2y = mxy; end
      else begin p1y = mxy; p2y = mny; end
      if (on_edge(p1x, p1y)) begin tx = p2x; ty = p2y; end
      else begin tx = p1x; ty = p1y; end
    end
  endtask

  task automatic clear_mask();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) mask[y][x] = 0;
  endtask

  task automatic draw_line(input int x0, input int y0, input int x1, input int y1);
    int dx = x1 - x0, dy = y1 - y0;
    int n = (dx < 0 ? -dx : dx) > (dy < 0 ? -dy : dy) ? (dx < 0 ? -dx : dx) : (dy < 0 ? -dy : dy);
    if (n == 0) begin mask[y0][x0] = 1; return; end
    for (int t = 0; t <= n; t++) mask[y0 + (dy*t)/n][x0 + (dx*t)/n] = 1;
  endtask

  // drive one frame; inputs change 1 time unit after a rising edge
  task automatic send_frame(input bit idle, input string tag);
    bit h; int tx, ty;
    model(h, tx, ty);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (idle && ($urandom % 8 == 0)) begin
          @(posedge clk); #1;
          pix_valid = 0; pix_on = $urandom % 2;  // R2: ignored garbage
          pix_x = 11'($urandom % W); pix_y = 11'($urandom % H);
        end
        @(posedge clk); #1;
        pix_valid = 1; pix_on = mask[y][x];
        pix_x = 11'(x); pix_y = 11'(y);
        if (x == W-1 && y == H-1) begin
          pend = 1; due = cyc + 3; exp_hit = h; exp_x = tx; exp_y = ty; exp_tag = tag;
        end
      end
  endtask

  task automatic go_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; pix_valid = 0; pix_on = 1;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pend && cyc == due - 1) begin
      check(!tip_valid && tip_x == 11'(last_x) && tip_y == 11'(last_y),
            "R9 tip held before pulse", int'(tip_x), last_x);
    end
    if (pend && cyc == due) begin
      pend = 0;
      if (exp_hit) begin
        check(tip_valid, {"R6 pulse timing ", exp_tag}, int'(tip_valid), 1);
        check(tip_x == 11'(exp_x), {exp_tag, " tip_x"}, int'(tip_x), exp_x);
        check(tip_y == 11'(exp_y), {exp_tag, " tip_y"}, int'(tip_y), exp_y);
        last_x = exp_x; last_y = exp_y;
      end else begin
        check(!tip_valid, "R7 no pulse on empty frame", int'(tip_valid), 0);
        check(tip_x == 11'(last_x) && tip_y == 11'(last_y), "R7 tip kept",
              int'(tip_x), last_x);
      end
    end else if (tip_valid) begin
      check(0, "R6 unexpected or extra pulse", 1, 0);
    end
  end

  initial begin
    int x0, y0, x1, y1;
    void'($urandom(32'd4242));
    #(CLK_PERIOD*3);
    check(tip_x == 0 && tip_y == 0 && !tip_valid, "R1 outputs in reset", int'(tip_x), 0);
    @(posedge clk); #1; rst_n = 1;
    go_idle(3);
    check(tip_x == 0 && tip_y == 0 && !tip_valid, "R1 outputs after reset", int'(tip_x), 0);

    clear_mask(); draw_line(0, 0, 20, 15);
    send_frame(1, "R4 entry at upper-left corner"); go_idle(5);
    clear_mask(); draw_line(0, 20, 25, 3);
    send_frame(1, "R3 lower-left to upper-right"); go_idle(5);
    clear_mask(); draw_line(5, 5, 10, 10);
    send_frame(1, "R4 no endpoint on border"); go_idle(5);
    clear_mask(); draw_line(0, 0, W-1, H-1);
    send_frame(1, "R5 both endpoints on border"); go_idle(5);
    clear_mask(); mask[9][7] = 1;
    send_frame(1, "R3 single pixel tie"); go_idle(5);
    clear_mask(); mask[10][W-1] = 1;
    send_frame(1, "R5 pixel on right border"); go_idle(5);
    clear_mask();
    send_frame(1, "R7 empty"); go_idle(5);

    for (int k = 0; k < 26; k++) begin
      clear_mask();
      if ($urandom % 2) begin x0 = 0; y0 = $urandom % H; end
      else begin x0 = $urandom % W; y0 = 0; end
      x1 = 2 + $urandom % (W-4); y1 = 2 + $urandom % (H-4);
      draw_line(x0, y0, x1, y1);
      if ($urandom % 3 == 0) draw_line(x1, y1, $urandom % W, $urandom % H);
      if (k % 4 == 3) begin
        send_frame(0, "R8 back-to-back first");
        clear_mask(); draw_line($urandom % W, $urandom % H, $urandom % W, $urandom % H);
        send_frame(0, "R8 back-to-back second");
      end else begin
        send_frame(1, "R2 random frame");
      end
      go_idle(4);
    end
    go_idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule